// File: doc/BRIEF.md
# Shadow Region Write-Protect Guard

This block sits between the processor bus and the memory and second-level cache controller of a PC-style chipset. It decides what happens to each bus cycle that lands in the upper-memory shadow window. That window is a run of 16 KB segments starting at address C0000h. Each segment has three configuration bits: read-from-RAM, write-protect and on-chip-cacheable. A write to a protected segment never reaches DRAM or the external cache. The block completes that write on the bus by itself, so the processor is not left waiting.

The processor's internal cache cannot protect lines by itself. The block therefore does two things to stop a discarded write from surviving on chip. First, during the discarded write it pulses the external snoop strobe once. The address of that same write is still on the bus, so the processor invalidates its own line. Second, on every line fill from a protected segment it forces the per-line write-back select to write-through. Later writes to that line then appear on the bus, where they can be blocked. A segment whose cacheable bit is cleared is never cached on chip: the cache-enable input is held inactive on its fills, and the snoop pulse is left out because no on-chip copy can exist.

Each accepted cycle is forwarded to the memory controller as a one-clock start pulse with a latched address, direction and RAM/ROM route. The memory controller's ready signal is passed back to the processor.

Top module: `shadow_wp_guard`

## Requirements
- R1: A write to a segment whose write-protect bit is 1 produces no `mem_start` pulse, so neither DRAM nor the external cache sees it.
- R2: A discarded write ends with `cpu_rdy_n` low for exactly one clock. That clock is the second clock after the edge that samples `cpu_ads_n` low.
- R3: A discarded write to a segment whose cacheable bit is 1 drives `cpu_eads_n` low for exactly one clock. That clock is the first clock after the edge that samples the address strobe, while the address is still held.
- R4: A discarded write to a segment whose cacheable bit is 0 leaves `cpu_eads_n` high for the whole cycle.
- R5: On a cycle to a protected, cacheable segment, `cpu_ken_n` is 0 and `cpu_line_wb` is 0 (write-through).
- R6: On a cycle to a segment whose cacheable bit is 0, `cpu_ken_n` is 1.
- R7: With the write-protect bit at 0, a write to a segment is forwarded with `mem_start` and its address, and `cpu_eads_n` stays high.
- R8: Cycles outside the window, and all reads, are forwarded unchanged with `cpu_eads_n` high. Outside the window, `cpu_ken_n` is 0 and `cpu_line_wb` is 1.
- R9: Segment n covers addresses C0000h + n*4000h up to C0000h + n*4000h + 3FFFh, for n from 0 to 15. BFFFFh and 100000h are outside the window.
- R10: `mem_ram_sel` equals the segment's read-from-RAM bit on reads inside the window, and is 1 for all writes and for every cycle outside the window.
- R11: After reset, `cpu_rdy_n`=1, `cpu_eads_n`=1, `mem_start`=0, `cpu_ken_n`=1 and `cpu_line_wb`=0.
- R12: On a forwarded cycle, `cpu_rdy_n` is low exactly in the clock where `mem_rdy` is 1. With a memory latency of L clocks after `mem_start`, that is clock 1+L after the strobe edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_ads_n | input | 1 | Processor address strobe, active low |
| cpu_wr | input | 1 | Cycle direction, 1 = write |
| cpu_addr | input | 32 | Processor byte address |
| cfg_rd_en | input | 16 | Per-segment read-from-RAM enable |
| cfg_wp | input | 16 | Per-segment write-protect |
| cfg_icache | input | 16 | Per-segment on-chip cacheable |
| mem_rdy | input | 1 | Memory controller ready for the forwarded cycle |
| mem_start | output | 1 | One-clock start of a forwarded cycle |
| mem_wr | output | 1 | Latched direction of the cycle |
| mem_addr | output | 32 | Latched address of the cycle |
| mem_ram_sel | output | 1 | 1 = route to shadow RAM, 0 = route to ROM |
| cpu_rdy_n | output | 1 | Ready to the processor, active low |
| cpu_eads_n | output | 1 | Snoop-invalidate strobe to the processor, active low |
| cpu_ken_n | output | 1 | Cache enable for the line fill, active low |
| cpu_line_wb | output | 1 | Per-line policy, 1 = write-back, 0 = write-through |

## Verification
The bench runs reads and writes outside the window, and at the two addresses just past each edge of it, to show that cycles outside pass untouched. Writes to the same segment are tried first with protection off and then with it on, which separates forwarding from discarding. Protected segments are tried with the cacheable bit set and cleared, which separates the snoop-pulse path from the no-cache fallback. Reads with the read-from-RAM bit set and cleared, at several memory latencies, check both routing and ready timing.

// File: rtl/shadow_guard_pkg.sv
package shadow_guard_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PASS, ST_SNOOP, ST_ACK} cyc_state_e;

  typedef struct packed {
    logic hit;
    logic rd_en;
    logic wp;
    logic icache;
  } seg_attr_t;

  typedef struct packed {
    logic discard;
    logic snoop;
    logic ken_n;
    logic line_wb;
    logic ram_sel;
  } cyc_policy_t;
endpackage

// File: rtl/shadow_region_decode.sv
module shadow_region_decode
  import shadow_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NREG = 16,
  parameter int SEG_SHIFT = 14,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h000C_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NREG-1:0]   cfg_rd_en,
  input  logic [NREG-1:0]   cfg_wp,
  input  logic [NREG-1:0]   cfg_icache,
  output logic [NREG-1:0]   seg_match,
  output seg_attr_t         attr
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;
  localparam logic [ADDR_W-1:0] WIN_SPAN = ADDR_W'(NREG) << SEG_SHIFT;

  // Window test: offset from base below the span, base itself included
  function automatic logic in_window(input logic [ADDR_W-1:0] a);
    return (a >= WIN_BASE) && ((a - WIN_BASE) < WIN_SPAN);
  endfunction

  // Segment number inside the window
  function automatic logic [IDX_W-1:0] seg_index(input logic [ADDR_W-1:0] a);
    return IDX_W'((a - WIN_BASE) >> SEG_SHIFT);
  endfunction

  logic             win_hit;
  logic [IDX_W-1:0] seg_idx;

  assign win_hit = in_window(addr);
  assign seg_idx = seg_index(addr);

  for (genvar g = 0; g < NREG; g++) begin : g_seg
    assign seg_match[g] = win_hit && (seg_idx == IDX_W'(g));
  end

  assign attr.hit    = |seg_match;
  assign attr.rd_en  = |(seg_match & cfg_rd_en);
  assign attr.wp     = |(seg_match & cfg_wp);
  assign attr.icache = |(seg_match & cfg_icache);
endmodule

// File: rtl/shadow_policy.sv
module shadow_policy
  import shadow_guard_pkg::*;
(
  input  seg_attr_t   attr,
  input  logic        is_write,
  output cyc_policy_t pol
);
  always_comb begin
    pol.discard = attr.hit && attr.wp && is_write;
    // no on-chip copy can exist when the segment is never cached
    pol.snoop   = pol.discard && attr.icache;
    pol.ken_n   = attr.hit ? !attr.icache : 1'b0;
    pol.line_wb = attr.hit ? !attr.wp : 1'b1;
    pol.ram_sel = (attr.hit && !is_write) ? attr.rd_en : 1'b1;
  end
endmodule

// File: rtl/shadow_cycle_fsm.sv
module shadow_cycle_fsm
  import shadow_guard_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ads_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  cyc_policy_t       pol,
  input  logic              mem_rdy,
  output logic              mem_start,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ram_sel,
  output logic              rdy_n,
  output logic              eads_n,
  output logic              ken_n,
  output logic              line_wb,
  output cyc_state_e        state
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      mem_start   <= 1'b0;
      mem_wr      <= 1'b0;
      mem_addr    <= '0;
      mem_ram_sel <= 1'b1;
      eads_n      <= 1'b1;
      ken_n       <= 1'b1;
      line_wb     <= 1'b0;
    end else begin
      mem_start <= 1'b0;
      eads_n    <= 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (!ads_n) begin
            mem_addr    <= addr;
            mem_wr      <= wr;
            mem_ram_sel <= pol.ram_sel;
            ken_n       <= pol.ken_n;
            line_wb     <= pol.line_wb;
            if (pol.discard) begin
              state  <= ST_SNOOP;
              eads_n <= !pol.snoop;
            end else begin
              state     <= ST_PASS;
              mem_start <= 1'b1;
            end
          end
        end
        ST_PASS:  if (mem_rdy) state <= ST_IDLE;
        ST_SNOOP: state <= ST_ACK;
        ST_ACK:   state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign rdy_n = !(((state == ST_PASS) && mem_rdy) || (state == ST_ACK));

  // R1: nothing reaches memory while a discarded write is in flight
  a_r1_no_mem_on_discard: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_SNOOP) || (state == ST_ACK)) |-> !mem_start);
  // R2: discarded write is acknowledged in the clock after the snoop clock
  a_r2_ack_after_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SNOOP) |=> !rdy_n);
  // R3: snoop strobe lasts a single clock
  a_r3_eads_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    !eads_n |=> eads_n);
  // R3: snoop strobe only while the discarded write holds its address
  a_r3_eads_in_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    !eads_n |-> (state == ST_SNOOP));
  // R3: snoop strobe follows an address strobe by one clock
  a_r3_eads_after_ads: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eads_n) |-> $past(!ads_n));
  // R12: forwarded cycle only completes on memory ready
  a_r12_rdy_from_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_n && (state == ST_PASS)) |-> mem_rdy);
endmodule

// File: rtl/shadow_wp_guard.sv
module shadow_wp_guard
  import shadow_guard_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NREG = 16,
  parameter int SEG_SHIFT = 14,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h000C_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_ads_n,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [NREG-1:0]   cfg_rd_en,
  input  logic [NREG-1:0]   cfg_wp,
  input  logic [NREG-1:0]   cfg_icache,
  input  logic              mem_rdy,
  output logic              mem_start,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ram_sel,
  output logic              cpu_rdy_n,
  output logic              cpu_eads_n,
  output logic              cpu_ken_n,
  output logic              cpu_line_wb
);
  seg_attr_t   seg_attr;
  cyc_policy_t cyc_pol;
  cyc_state_e  cyc_state;
  logic [NREG-1:0] seg_match;

  shadow_region_decode #(
    .ADDR_W(ADDR_W), .NREG(NREG), .SEG_SHIFT(SEG_SHIFT), .WIN_BASE(WIN_BASE)
  ) u_decode (
    .addr(cpu_addr), .cfg_rd_en(cfg_rd_en), .cfg_wp(cfg_wp),
    .cfg_icache(cfg_icache), .seg_match(seg_match), .attr(seg_attr)
  );

  shadow_policy u_policy (
    .attr(seg_attr), .is_write(cpu_wr), .pol(cyc_pol)
  );

  shadow_cycle_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ads_n(cpu_ads_n), .wr(cpu_wr), .addr(cpu_addr),
    .pol(cyc_pol), .mem_rdy(mem_rdy), .mem_start(mem_start), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_ram_sel(mem_ram_sel), .rdy_n(cpu_rdy_n),
    .eads_n(cpu_eads_n), .ken_n(cpu_ken_n), .line_wb(cpu_line_wb),
    .state(cyc_state)
  );

  // R9: an address falls in at most one segment
  a_r9_single_segment: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(seg_match));
  // R6: strobed cycle to a never-cached segment leaves cache enable off
  a_r6_ken_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_ads_n && (cyc_state == ST_IDLE) && seg_attr.hit && !seg_attr.icache)
      |=> cpu_ken_n);
  // R4: never-cached protected write gives no snoop strobe
  a_r4_no_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_ads_n && (cyc_state == ST_IDLE) && cpu_wr && seg_attr.wp && !seg_attr.icache)
      |=> cpu_eads_n);
endmodule

// File: tb/shadow_wp_guard_test.sv
module shadow_wp_guard_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic        mem;
    logic        snoop;
    logic        ken_n;
    logic        wb;
    logic        ram;
    logic        wr;
    logic [31:0] addr;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_ads_n = 1'b1;
  logic cpu_wr = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic [15:0] cfg_rd_en = '0;
  logic [15:0] cfg_wp = '0;
  logic [15:0] cfg_icache = '0;
  logic mem_rdy = 1'b0;
  logic mem_start, mem_wr, mem_ram_sel, cpu_rdy_n, cpu_eads_n, cpu_ken_n, cpu_line_wb;
  logic [31:0] mem_addr;

  int tests = 0;
  int fails = 0;
  int lat = 1;
  int mem_cnt = 0;
  exp_t sb[$];

  shadow_wp_guard uut (
    .clk(clk), .rst_n(rst_n), .cpu_ads_n(cpu_ads_n), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cfg_rd_en(cfg_rd_en), .cfg_wp(cfg_wp),
    .cfg_icache(cfg_icache), .mem_rdy(mem_rdy), .mem_start(mem_start),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_ram_sel(mem_ram_sel),
    .cpu_rdy_n(cpu_rdy_n), .cpu_eads_n(cpu_eads_n), .cpu_ken_n(cpu_ken_n),
    .cpu_line_wb(cpu_line_wb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Model: window is C0000h..FFFFFh, segment number is address bits 17:14
  function automatic exp_t model(input logic [31:0] a, input logic w);
    exp_t e;
    logic inwin;
    int s;
    inwin = (a[31:18] == 14'h3);
    s = int'(a[17:14]);
    e.addr = a;
    e.wr = w;
    if (!inwin) begin
      e.mem = 1; e.snoop = 0; e.ken_n = 0; e.wb = 1; e.ram = 1;
    end else begin
      e.mem   = !(w && cfg_wp[s]);
      e.snoop = w && cfg_wp[s] && cfg_icache[s];
      e.ken_n = !cfg_icache[s];
      e.wb    = !cfg_wp[s];
      e.ram   = w ? 1'b1 : cfg_rd_en[s];
    end
    return e;
  endfunction

  // Driver: one bus cycle, pushes the expected item, checks ready timing
  task automatic bus_cycle(input logic [31:0] a, input logic w, input int l);
    exp_t e;
    int k;
    @(negedge clk);
    e = model(a, w);
    sb.push_back(e);
    lat = l;
    cpu_addr = a; cpu_wr = w; cpu_ads_n = 1'b0;
    k = 0;
    do begin
      @(negedge clk);
      cpu_ads_n = 1'b1;
      k++;
    end while (cpu_rdy_n !== 1'b0 && k < 50);
    if (e.mem) check("R12 ready clock of forwarded cycle", k, 1 + l);
    else       check("R2 ready clock of discarded write", k, 2);
  endtask

  // Memory responder: ready one clock, lat clocks after mem_start
  always @(posedge clk) begin
    #2;
    mem_rdy = 1'b0;
    if (mem_start) mem_cnt = lat;
    else if (mem_cnt > 0) begin
      mem_cnt--;
      if (mem_cnt == 0) mem_rdy = 1'b1;
    end
  end

  // Monitor: collects what the cycle did and compares at the ready clock
  logic seen_mem = 0;
  logic [31:0] seen_addr = '0;
  logic seen_wr = 0;
  logic seen_ram = 0;
  int eads_cnt = 0;
  logic prev_eads = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_start) begin
        seen_mem = 1; seen_addr = mem_addr; seen_wr = mem_wr; seen_ram = mem_ram_sel;
      end
      if (!cpu_eads_n) eads_cnt++;
      if (!cpu_rdy_n) begin
        if (sb.size() == 0) begin
          check("R12 ready without a cycle", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.mem ? "R7/R8 forwarded to memory" : "R1 write discarded", 32'(seen_mem), 32'(e.mem));
          check(e.snoop ? "R3 snoop pulse count" : "R4/R8 no snoop pulse", eads_cnt, e.snoop ? 1 : 0);
          if (e.snoop) check("R3 snoop one clock before ready", 32'(prev_eads), 1);
          check("R5/R6/R8 cache enable", 32'(cpu_ken_n), 32'(e.ken_n));
          check("R5/R8 line write-back select", 32'(cpu_line_wb), 32'(e.wb));
          if (e.mem) begin
            check("R9 forwarded address", seen_addr, e.addr);
            check("R7 forwarded direction", 32'(seen_wr), 32'(e.wr));
            check("R10 RAM route", 32'(seen_ram), 32'(e.ram));
            check("R12 ready with mem_rdy", 32'(mem_rdy), 1);
          end
        end
        seen_mem = 0; eads_cnt = 0;
      end
      prev_eads = !cpu_eads_n;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 rdy_n", 32'(cpu_rdy_n), 1);
    check("R11 eads_n", 32'(cpu_eads_n), 1);
    check("R11 mem_start", 32'(mem_start), 0);
    check("R11 ken_n", 32'(cpu_ken_n), 1);
    check("R11 line_wb", 32'(cpu_line_wb), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle after reset", 32'(cpu_rdy_n), 1);

    // R8 outside the window
    bus_cycle(32'h0000_1000, 1'b0, 1);
    bus_cycle(32'h0000_2004, 1'b1, 3);
    // R7 protection off: copy into the shadow segment passes
    cfg_icache = 16'hFFDF;
    bus_cycle(32'h000C_8010, 1'b1, 2);
    bus_cycle(32'h000C_8010, 1'b0, 1);
    // protection on: R1 R2 R3 R5
    cfg_wp = 16'h8024;
    cfg_rd_en = 16'h8004;
    bus_cycle(32'h000C_8010, 1'b1, 1);
    bus_cycle(32'h000C_8010, 1'b0, 2);
    bus_cycle(32'h000C_BFFC, 1'b1, 1);
    // R4 R6 never-cached protected segment 5
    bus_cycle(32'h000D_4000, 1'b1, 1);
    bus_cycle(32'h000D_4000, 1'b0, 1);
    // R10 read from segment with RAM route off
    bus_cycle(32'h000C_0000, 1'b0, 4);
    // R9 boundaries
    bus_cycle(32'h000B_FFFC, 1'b1, 1);
    bus_cycle(32'h000F_FFFC, 1'b1, 1);
    bus_cycle(32'h000F_FFFC, 1'b0, 2);
    bus_cycle(32'h0010_0000, 1'b1, 1);
    bus_cycle(32'h000C_C000, 1'b1, 1);
    // back-to-back discarded then forwarded
    bus_cycle(32'h000C_9000, 1'b1, 1);
    bus_cycle(32'h0003_0000, 1'b0, 2);

    repeat (4) @(negedge clk);
    check("R12 scoreboard drained", sb.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule